// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and steers each one onto one of fifteen output interrupt lines, or onto none. Software configures it through a small 32-bit register port. It can enable each source in a mask word and read the synchronized raw source levels in a status word. Four steering words hold a 4-bit line code for every source.

A source drives its selected output line only while it is enabled and its synchronized level is high. Because the sources are levels, an output line drops as soon as every source feeding it has been released or masked. Software finds the work it must do by ANDing the mask word with the status word. The register port is a plain strobe interface: a write takes effect at the clock edge on which its strobe is high, and read data appears on the following cycle. No back-pressure is involved.

Top module: `irq_route_ctrl`

## Requirements
- R1: While reset is low, and after it is released, the mask word and all line codes are 0, every output line is low and `bus_rdata` is 0.
- R2: Offset 0x00 is the mask word, one enable bit per source, with bit n enabling source n. It is read/write in all 32 bits.
- R3: Offset 0x04 is the status word. Bit n shows the level of `irq_src[n]` sampled through two clock stages, whatever the mask holds. It is read-only, so a write to 0x04 changes nothing.
- R4: Line codes are 4 bits per source and are packed in reverse word order. Source n sits at offset 0x08 + 4*(3 - n/8), in bits [4*(n%8)+3 : 4*(n%8)]. So 0x14 holds sources 0..7 and 0x08 holds sources 24..31. All four words are read/write.
- R5: Line code 0 connects the source to no output. Line code c in 1..15 connects it to `irq_line[c-1]`.
- R6: `irq_line[k]` is high exactly when some source has its mask bit set, its status bit set and line code k+1. The line is registered one cycle after the status word, so a source change at one clock edge reaches the line three edges later.
- R7: An output line falls once every source routed to it has been held low long enough to pass through the status and line registers. No pending state is latched.
- R8: Word offsets 0x18 and 0x1C are unmapped. Reads there return 0, and writes there change no register. Address bits [1:0] are ignored.
- R9: `bus_rdata` is registered. It carries the addressed word in the cycle after `bus_rd` is high, and 0 after a cycle with no read. When a read and a write hit the same word in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | 32 | Level interrupt sources, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 5 | Byte offset of the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_line | output | 15 | Routed output interrupt lines |

## Verification
Register access and line generation can fall in the same cycle. A write to the mask or a steering word can land on the same edge where a source level reaches the status word. A read and a write can also target the same word together. The bench provokes both. It changes sources while it rewrites mask and codes, and it issues combined read/write strobes on the mask word. A behavioural model compares the design with the expected values on every clock. Under that model, a write is seen by the line logic from the next edge onward, and a combined access returns the value from before the write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Word indices of the register port (byte offset >> 2)
  localparam int WORD_MASK  = 0;
  localparam int WORD_STAT  = 1;
  localparam int WORD_ROUTE = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int N_IN   = 32,
  parameter int DATA_W = 32,
  parameter int CODE_W = 4,
  parameter int AW     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [AW-1:0]        addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [N_IN-1:0]      status,
  output logic [DATA_W-1:0]    rdata,
  output logic [N_IN-1:0]      mask,
  output logic [N_IN*CODE_W-1:0] codes
);
  localparam int PER_REG = DATA_W / CODE_W;
  localparam int N_RREG  = N_IN / PER_REG;

  logic [DATA_W-1:0] rreg_q [N_RREG];
  logic [DATA_W-1:0] rd_mux;
  int                word;

  assign word = int'(addr[AW-1:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      for (int r = 0; r < N_RREG; r++) rreg_q[r] <= '0;
    end else if (wr) begin
      if (word == WORD_MASK) mask <= wdata[N_IN-1:0];
      for (int r = 0; r < N_RREG; r++)
        if (word == WORD_ROUTE + r) rreg_q[r] <= wdata;
    end
  end

  // Reversed packing: the last steering word holds the lowest sources
  for (genvar n = 0; n < N_IN; n++) begin : g_code
    assign codes[n*CODE_W +: CODE_W] =
      rreg_q[N_RREG-1-(n/PER_REG)][(n%PER_REG)*CODE_W +: CODE_W];
  end

  always_comb begin
    rd_mux = '0;
    if (word == WORD_MASK) rd_mux[N_IN-1:0] = mask;
    if (word == WORD_STAT) rd_mux[N_IN-1:0] = status;
    for (int r = 0; r < N_RREG; r++)
      if (word == WORD_ROUTE + r) rd_mux = rreg_q[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd ? rd_mux : '0;
  end
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
  parameter int N_IN   = 32,
  parameter int CODE_W = 4,
  parameter int N_LINE = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        mask,
  input  logic [N_IN-1:0]        status,
  input  logic [N_IN*CODE_W-1:0] codes,
  output logic [N_LINE-1:0]      line
);
  logic [N_IN-1:0]   live;
  logic [N_LINE-1:0] hit;

  assign live = mask & status;

  always_comb begin
    hit = '0;
    for (int k = 0; k < N_LINE; k++)
      for (int n = 0; n < N_IN; n++)
        hit[k] = hit[k] |
          (live[n] && (codes[n*CODE_W +: CODE_W] == CODE_W'(k + 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line <= '0;
    else        line <= hit;
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int N_IN        = 32,
  parameter int DATA_W      = 32,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 5,
  localparam int N_LINE     = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   irq_src,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_LINE-1:0] irq_line
);
  logic [N_IN-1:0]        status;
  logic [N_IN-1:0]        mask;
  logic [N_IN*CODE_W-1:0] codes;

  irq_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_src), .dout(status)
  );

  irq_route_regs #(.N_IN(N_IN), .DATA_W(DATA_W), .CODE_W(CODE_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .status(status), .rdata(bus_rdata),
    .mask(mask), .codes(codes)
  );

  irq_line_gen #(.N_IN(N_IN), .CODE_W(CODE_W), .N_LINE(N_LINE)) u_lines (
    .clk(clk), .rst_n(rst_n), .mask(mask), .status(status),
    .codes(codes), .line(irq_line)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int N_IN   = 32,
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  parameter int N_LINE = 15,
  parameter int N_WORD = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_IN-1:0]   irq_src,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [AW-1:0]     bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_LINE-1:0] irq_line
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_line == '0 && bus_rdata == '0));

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && int'(bus_addr[AW-1:2]) >= N_WORD) |=> bus_rdata == '0);

  // R2
  mask_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr[AW-1:2] == '0 &&
     $past(bus_wr && bus_addr[AW-1:2] == '0))
    |=> bus_rdata[N_IN-1:0] == $past(bus_wdata[N_IN-1:0], 2));

  // R7
  lines_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_src, 3) == '0) |-> irq_line == '0);
endmodule

bind irq_route_ctrl irq_route_chk #(
  .N_IN(N_IN), .DATA_W(DATA_W), .AW(AW), .N_LINE(N_LINE),
  .N_WORD(2 + N_IN * CODE_W / DATA_W)
) u_chk (.*);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_src = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [14:0] irq_line;

  int    n_checks = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  irq_route_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_line(irq_line)
  );

  // Behavioural reference model
  int          m_code [32];
  logic [31:0] m_mask = '0, m_s1 = '0, m_s2 = '0, m_rdata = '0;
  logic [14:0] m_line = '0;
  logic [31:0] nrd;
  logic [14:0] nl;
  int          w;

  initial for (int n = 0; n < 32; n++) m_code[n] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '0; m_s1 = '0; m_s2 = '0; m_rdata = '0; m_line = '0;
      for (int n = 0; n < 32; n++) m_code[n] = 0;
    end else begin
      w = int'(bus_addr >> 2);
      nrd = '0;
      if (bus_rd) begin
        if (w == 0) nrd = m_mask;
        else if (w == 1) nrd = m_s2;
        else if (w >= 2 && w <= 5)
          for (int j = 0; j < 8; j++) nrd[4*j +: 4] = 4'(m_code[8*(5-w)+j]);
      end
      nl = '0;
      for (int n = 0; n < 32; n++)
        if (m_mask[n] && m_s2[n] && m_code[n] != 0) nl[m_code[n]-1] = 1'b1;
      if (bus_wr) begin
        if (w == 0) m_mask = bus_wdata;
        else if (w >= 2 && w <= 5)
          for (int j = 0; j < 8; j++) m_code[8*(5-w)+j] = int'(bus_wdata[4*j +: 4]);
      end
      m_s2 = m_s1;
      m_s1 = irq_src;
      m_line = nl;
      m_rdata = nrd;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (irq_line !== m_line || bus_rdata !== m_rdata) begin
        n_fail++;
        $display("FAIL %s model: line=%h rdata=%h expected line=%h rdata=%h",
                 tag, irq_line, bus_rdata, m_line, m_rdata);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick(1); bus_wr = 0;
  endtask

  task automatic rd_expect(input logic [4:0] a, input logic [31:0] exp, input string req);
    bus_rd = 1; bus_addr = a; tick(1); bus_rd = 0;
    n_checks++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read %h: actual=%h expected=%h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic line_expect(input logic [14:0] exp, input string req);
    n_checks++;
    if (irq_line !== exp) begin
      n_fail++;
      $display("FAIL %s line: actual=%h expected=%h", req, irq_line, exp);
    end
  endtask

  initial begin
    tick(3);
    line_expect(15'h0, "R1");
    rst_n = 1; tick(1);
    rd_expect(5'h00, 32'h0, "R1");
    rd_expect(5'h08, 32'h0, "R1");

    tag = "R2";
    wr(5'h00, 32'hA5A5_1234);
    rd_expect(5'h00, 32'hA5A5_1234, "R2");
    rd_expect(5'h03, 32'hA5A5_1234, "R2");

    tag = "R3";
    wr(5'h00, 32'h0);
    irq_src = 32'h8000_0101; tick(3);
    rd_expect(5'h04, 32'h8000_0101, "R3");
    wr(5'h04, 32'hFFFF_FFFF);
    rd_expect(5'h04, 32'h8000_0101, "R3");
    line_expect(15'h0, "R3");
    irq_src = '0; tick(4);

    tag = "R4";
    wr(5'h14, 32'h8765_4321);
    wr(5'h08, 32'hF000_0000);
    rd_expect(5'h14, 32'h8765_4321, "R4");
    rd_expect(5'h08, 32'hF000_0000, "R4");
    rd_expect(5'h0C, 32'h0, "R4");

    tag = "R6";
    wr(5'h00, 32'hFFFF_FFFF);
    irq_src = 32'h0000_0001; tick(2);
    line_expect(15'h0, "R6");
    tick(1);
    line_expect(15'h0001, "R6");
    irq_src = 32'h8000_0080; tick(4);
    line_expect(15'h4080, "R6");

    tag = "R5";
    irq_src = 32'h0000_0100; tick(4);
    line_expect(15'h0, "R5");
    wr(5'h10, 32'h0000_0002);
    tick(3);
    line_expect(15'h0002, "R5");

    tag = "R7";
    irq_src = '0; tick(4);
    line_expect(15'h0, "R7");

    tag = "R8";
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'h1234_5678);
    rd_expect(5'h18, 32'h0, "R8");
    rd_expect(5'h1C, 32'h0, "R8");
    rd_expect(5'h00, 32'hFFFF_FFFF, "R8");

    tag = "R9";
    tick(1);
    n_checks++;
    if (bus_rdata !== 32'h0) begin
      n_fail++;
      $display("FAIL R9 idle rdata: actual=%h expected=%h", bus_rdata, 32'h0);
    end
    bus_rd = 1; bus_wr = 1; bus_addr = 5'h00; bus_wdata = 32'h0000_00F0; tick(1);
    bus_rd = 0; bus_wr = 0;
    n_checks++;
    if (bus_rdata !== 32'hFFFF_FFFF) begin
      n_fail++;
      $display("FAIL R9 collision: actual=%h expected=%h", bus_rdata, 32'hFFFF_FFFF);
    end
    rd_expect(5'h00, 32'h0000_00F0, "R9");

    tag = "R6";
    for (int i = 0; i < 200; i++) begin
      irq_src = 32'h1 << (i % 32) | 32'h3 << ((i * 7) % 30);
      if (i % 5 == 0) wr(5'h00, 32'hFFFF_FFFF ^ (32'h1 << (i % 32)));
      else if (i % 7 == 0) wr(5'(8 + 4 * (i % 4)), 32'h9ABC_DEF1 + 32'(i));
      else tick(1);
    end
    irq_src = '0; tick(5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule